// File: doc/BRIEF.md
# Multicycle Word-Addressed RISC Core

This block is a small 32-bit load/store processor that is not pipelined. Each instruction is moved through a named state sequence by an explicit controller. The core first fetches the instruction and reads its operands. It then takes a path chosen by the instruction class: register-register ALU, add-immediate, load, store, conditional branch or jump. The program counter, the instruction register, the operand latches, a result latch and a 32-entry register file all sit inside the block.

Instructions and data share one word-addressed memory port. The core drives `mem_addr` and expects `mem_rdata` to show that word in the same cycle. A write is committed at the rising clock edge on which `mem_we` is high. The program counter counts bytes; the port address is the program counter with its two low bits dropped. The core supports `add`, `sub`, `slt`, `addi`, `lw`, `sw`, `beq` and `j`. An all-ones instruction word parks the core in a halt state, which lets a test harness end a program cleanly.

States and transitions:
- `S_FETCH` goes to `S_DECODE`, or to `S_HALT` on an all-ones word.
- `S_DECODE` goes to one of `S_RR`, `S_RI`, `S_ADDR`, `S_BR` or `S_JMP`. It returns to `S_FETCH` on an undefined opcode or function code.
- `S_RR` and `S_RI` go to `S_WB`.
- `S_ADDR` goes to `S_LD` for a load and to `S_ST` for a store.
- `S_LD` goes to `S_WB`.
- `S_ST`, `S_BR`, `S_JMP` and `S_WB` go to `S_FETCH`.
- `S_HALT` loops on itself.

Top module: `mc_cpu`

## Requirements
- R1: While reset is active, the program counter is 0 and the controller sits in `S_FETCH`, so `mem_addr` is 0. In this state `mem_we` and `halt` are low.
- R2: The fetch state loads the instruction register from the word at PC and advances PC by 4. `mem_addr` is PC divided by 4.
- R3: An instruction with opcode 000000 and function code 100000 (add), 100010 (sub) or 101010 (slt, signed compare giving 1 or 0) writes that function of the registers in bits 25:21 and 20:16 to the register in bits 15:11.
- R4: Opcode 001000 (addi) writes the register in bits 25:21 plus the sign-extended bits 15:0 into the register in bits 20:16.
- R5: Opcode 100011 (lw) loads the word at byte address rs + sign-extended immediate into rt. Opcode 101011 (sw) writes rt to that address.
- R6: Opcode 000100 (beq) sets PC to the incremented PC plus the sign-extended immediate times 4 when its two registers are equal. Otherwise execution continues with the next instruction.
- R7: Opcode 000010 (j) sets PC to the upper 4 bits of the incremented PC joined with bits 25:0 shifted left by 2.
- R8: Register 0 always reads as zero, and a write to it is discarded.
- R9: An undefined opcode, or an opcode of 000000 with an undefined function code, returns to fetch after its decode cycle and changes no register and no memory word.
- R10: Fetching the word 0xFFFFFFFF raises `halt` on the next cycle. `halt` stays high and no further memory write occurs.
- R11: Each class takes a fixed number of cycles counted from its fetch: load 5; add/sub/slt, addi and store 4; beq and j 3; undefined 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Word address for fetch, load or store |
| mem_we | output | 1 | Write strobe, committed at the clock edge |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Word at `mem_addr`, valid in the same cycle |
| halt | output | 1 | High once the halt word has been fetched |

## Verification
The hardest behaviour to observe is an instruction that must leave no trace: an undefined function code that names a live destination register, or a write to register 0. Register contents are not visible at the ports, so each test program follows these instructions with stores of every register they could have touched. The stored words are then compared in memory. The bench also counts clock edges from reset to `halt` and checks the total against the sum of the per-class cycle costs. This exposes any extra or missing state on the undefined paths.
// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_RR, S_RI, S_ADDR,
        S_LD, S_ST, S_BR, S_JMP, S_WB, S_HALT
    } state_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_t;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_J     = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_SLT = 6'b101010;

    localparam logic [31:0] HALT_WORD = 32'hFFFF_FFFF;
endpackage
// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [DW-1:0] rda,
    output logic [DW-1:0] rdb,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rda = regs[ra];
    assign rdb = regs[rb];

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ra == '0) |-> (rda == '0)); // R8
endmodule
// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_t       op,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
            default: y = a + b;
        endcase
    end
endmodule
// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  opc,
    input  logic [5:0]  fn,
    input  logic [31:0] fetch_word,
    output state_t      state,
    output logic        ir_ld,
    output logic        pc_inc,
    output logic        ab_ld,
    output logic        res_alu_ld,
    output logic        res_mem_ld,
    output logic        use_res_addr,
    output logic        alu_b_imm,
    output alu_op_t     alu_op,
    output logic        mem_we,
    output logic        rf_we,
    output logic        dst_is_rd,
    output logic        br_try,
    output logic        jmp_go,
    output logic        halt
);
    state_t nxt;
    logic   dst_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_FETCH;
            dst_rd_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_RR) dst_rd_q <= 1'b1;
            else if (state == S_RI || state == S_LD) dst_rd_q <= 1'b0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_FETCH:  nxt = (fetch_word == HALT_WORD) ? S_HALT : S_DECODE;
            S_DECODE: begin
                if (opc == OPC_RTYPE)
                    nxt = (fn == FN_ADD || fn == FN_SUB || fn == FN_SLT) ? S_RR : S_FETCH;
                else if (opc == OPC_ADDI) nxt = S_RI;
                else if (opc == OPC_LW || opc == OPC_SW) nxt = S_ADDR;
                else if (opc == OPC_BEQ) nxt = S_BR;
                else if (opc == OPC_J) nxt = S_JMP;
                else nxt = S_FETCH;
            end
            S_RR, S_RI: nxt = S_WB;
            S_ADDR:   nxt = (opc == OPC_LW) ? S_LD : S_ST;
            S_LD:     nxt = S_WB;
            S_ST, S_BR, S_JMP, S_WB: nxt = S_FETCH;
            S_HALT:   nxt = S_HALT;
            default:  nxt = S_FETCH;
        endcase
    end

    always_comb begin
        ir_ld = 1'b0; pc_inc = 1'b0; ab_ld = 1'b0;
        res_alu_ld = 1'b0; res_mem_ld = 1'b0; use_res_addr = 1'b0;
        alu_b_imm = 1'b0; alu_op = ALU_ADD; mem_we = 1'b0;
        rf_we = 1'b0; br_try = 1'b0; jmp_go = 1'b0; halt = 1'b0;
        dst_is_rd = dst_rd_q;
        unique case (state)
            S_FETCH:  begin ir_ld = 1'b1; pc_inc = 1'b1; end
            S_DECODE: ab_ld = 1'b1;
            S_RR: begin
                res_alu_ld = 1'b1;
                alu_op = (fn == FN_SUB) ? ALU_SUB : (fn == FN_SLT) ? ALU_SLT : ALU_ADD;
            end
            S_RI, S_ADDR: begin res_alu_ld = 1'b1; alu_b_imm = 1'b1; end
            S_LD:     begin use_res_addr = 1'b1; res_mem_ld = 1'b1; end
            S_ST:     begin use_res_addr = 1'b1; mem_we = 1'b1; end
            S_BR:     br_try = 1'b1;
            S_JMP:    jmp_go = 1'b1;
            S_WB:     rf_we = 1'b1;
            S_HALT:   halt = 1'b1;
            default:  ;
        endcase
    end

    AST_WB_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB) |=> (state == S_FETCH)); // R11
    AST_LOAD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LD) |-> ($past(state) == S_ADDR && $past(state, 2) == S_DECODE)); // R11
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt); // R10
    AST_HALT_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> ($past(state) == S_FETCH && $past(fetch_word) == HALT_WORD)); // R10
endmodule
// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              halt
);
    localparam int DW   = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    logic [DW-1:0] pc_q, ir_q, a_q, b_q, res_q;
    logic [DW-1:0] rda, rdb, imm_sx, alu_b, alu_y;
    logic [RAW-1:0] wa;
    state_t  state;
    alu_op_t alu_op;
    logic ir_ld, pc_inc, ab_ld, res_alu_ld, res_mem_ld, use_res_addr;
    logic alu_b_imm, rf_we, dst_is_rd, br_try, jmp_go;

    mc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .opc(ir_q[31:26]), .fn(ir_q[5:0]),
        .fetch_word(mem_rdata), .state(state), .ir_ld(ir_ld), .pc_inc(pc_inc),
        .ab_ld(ab_ld), .res_alu_ld(res_alu_ld), .res_mem_ld(res_mem_ld),
        .use_res_addr(use_res_addr), .alu_b_imm(alu_b_imm), .alu_op(alu_op),
        .mem_we(mem_we), .rf_we(rf_we), .dst_is_rd(dst_is_rd), .br_try(br_try),
        .jmp_go(jmp_go), .halt(halt)
    );

    assign imm_sx = {{16{ir_q[15]}}, ir_q[15:0]};
    assign alu_b  = alu_b_imm ? imm_sx : b_q;
    assign wa     = dst_is_rd ? ir_q[15:11] : ir_q[20:16];

    mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .ra(ir_q[25:21]), .rb(ir_q[20:16]),
        .rda(rda), .rdb(rdb), .we(rf_we), .wa(wa), .wd(res_q)
    );

    mc_alu #(.DW(DW)) u_alu (.a(a_q), .b(alu_b), .op(alu_op), .y(alu_y));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0; ir_q <= '0; a_q <= '0; b_q <= '0; res_q <= '0;
        end else begin
            if (ir_ld) ir_q <= mem_rdata;
            if (pc_inc) pc_q <= pc_q + 32'd4;
            else if (br_try && (a_q == b_q)) pc_q <= pc_q + {imm_sx[29:0], 2'b00};
            else if (jmp_go) pc_q <= {pc_q[31:28], ir_q[25:0], 2'b00};
            if (ab_ld) begin a_q <= rda; b_q <= rdb; end
            if (res_alu_ld) res_q <= alu_y;
            else if (res_mem_ld) res_q <= mem_rdata;
        end
    end

    assign mem_addr  = use_res_addr ? res_q[ADDR_W+1:2] : pc_q[ADDR_W+1:2];
    assign mem_wdata = b_q;

    AST_PC_STEPS_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
    AST_PC_HELD_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB || state == S_ST) |=> $stable(pc_q)); // R9
    AST_NO_STORE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_we); // R10
endmodule
// File: tb/sim_mc_cpu.sv
module sim_mc_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        halt;
    logic [31:0] mem [256];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    mc_cpu u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
               .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halt(halt));

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rt_w(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction

    function automatic logic [31:0] it_w(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] vals [6];
        logic [15:0] imms [6];
        vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h5;
        imms[0] = 16'h8000; imms[1] = 16'h7FFF; imms[2] = 16'hFFFF;
        imms[3] = 16'h0000; imms[4] = 16'h0003; imms[5] = 16'hFFF0;

        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                logic [31:0] a, b, sx, exp_r6;
                int n_exp, k;
                a = vals[i]; b = vals[j];
                sx = {{16{imms[j][15]}}, imms[j]};
                rst_n = 1'b0;
                for (int m = 0; m < 256; m++) mem[m] = 32'h0;
                mem[0]  = it_w(6'b100011, 0, 1, 16'h0100);   // lw r1
                mem[1]  = it_w(6'b100011, 0, 2, 16'h0104);   // lw r2
                mem[2]  = rt_w(1, 2, 3, 6'b100000);          // add
                mem[3]  = rt_w(1, 2, 4, 6'b100010);          // sub
                mem[4]  = rt_w(1, 2, 5, 6'b101010);          // slt
                mem[5]  = it_w(6'b001000, 1, 6, imms[j]);    // addi r6
                mem[6]  = rt_w(1, 2, 6, 6'b111111);          // undefined funct -> r6
                mem[7]  = 32'hFC00_0000;                     // undefined opcode
                mem[8]  = rt_w(1, 2, 0, 6'b100000);          // add r0
                mem[9]  = it_w(6'b000100, 1, 2, 16'h0001);   // beq r1,r2,+1
                mem[10] = it_w(6'b001000, 0, 7, 16'h0001);   // addi r7
                mem[11] = {6'b000010, 26'd13};               // j 13
                mem[12] = it_w(6'b001000, 0, 8, 16'h0005);   // skipped
                for (int s = 0; s < 7; s++)
                    mem[13+s] = it_w(6'b101011, 0, (s == 4) ? 0 : s + 3 - ((s > 4) ? 1 : 0), 16'(16'h0200 + 4*s));
                mem[20] = it_w(6'b000100, 0, 0, 16'h0001);   // beq r0,r0,+1
                mem[21] = it_w(6'b101011, 0, 1, 16'h021C);   // skipped
                mem[22] = it_w(6'b101011, 0, 2, 16'h0220);
                mem[23] = 32'hFFFF_FFFF;
                mem[64] = a; mem[65] = b; mem[135] = 32'hDEAD_BEEF;
                @(negedge clk);
                @(negedge clk);
                if (i == 0 && j == 0) begin
                    check(mem_addr == 10'd0, "R1 reset address", 32'(mem_addr), 32'h0);
                    check(!mem_we, "R1 reset write strobe", 32'(mem_we), 32'h0);
                    check(!halt, "R1 reset halt", 32'(halt), 32'h0);
                end
                rst_n = 1'b1;
                n_exp = 5 + 5 + 4*4 + 2 + 2 + 4 + 3 + ((a == b) ? 0 : 4) + 3 + 7*4 + 3 + 4;
                k = 0;
                do begin
                    @(posedge clk); #1; k++;
                end while (!halt && k < 300);
                check(k == n_exp + 1, "R11 cycles to halt", 32'(k), 32'(n_exp + 1));
                exp_r6 = a + sx;
                check(mem[128] == a + b, "R3 add", mem[128], a + b);
                check(mem[129] == a - b, "R3 sub", mem[129], a - b);
                check(mem[130] == (($signed(a) < $signed(b)) ? 32'd1 : 32'd0), "R3 slt", mem[130],
                      ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
                check(mem[131] == exp_r6, "R4/R9 addi kept past undefined", mem[131], exp_r6);
                check(mem[132] == 32'h0, "R8 r0 write discarded", mem[132], 32'h0);
                check(mem[133] == ((a == b) ? 32'd0 : 32'd1), "R6 beq", mem[133], (a == b) ? 32'd0 : 32'd1);
                check(mem[134] == 32'h0, "R7 jump skip", mem[134], 32'h0);
                check(mem[135] == 32'hDEAD_BEEF, "R6 taken beq skips store", mem[135], 32'hDEAD_BEEF);
                check(mem[136] == b, "R5 load then store", mem[136], b);
                check(mem[64] == a && mem[65] == b, "R5 loads leave source", mem[64], a);
                repeat (3) @(posedge clk);
                #1;
                check(halt && !mem_we, "R10 halt sticky", 32'(halt), 32'h1);
                check(mem[23] == 32'hFFFF_FFFF, "R10 no write after halt", mem[23], 32'hFFFF_FFFF);
                check(mem[7] == 32'hFC00_0000, "R9 no memory change", mem[7], 32'hFC00_0000);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule